// File: doc/BRIEF.md
# Bus Error Code Capture Register

This block keeps a record of the first CAN bus error that the protocol engine reports and holds it until software reads it. The engine signals each detected error with a one-cycle pulse. With the pulse it supplies a 2-bit error kind, a direction bit that says whether the node was sending or receiving, and a 5-bit code that names the frame position where the error happened. The block packs these into a 32-bit word that software can read.

Every reported error produces a bus error interrupt pulse. Only the first error after the capture is armed is stored. Later errors still raise the interrupt, but the stored word stays as it is until software reads it. A read strobe from the register decoder re-arms the capture. If an error arrives in the same cycle as the read, that error is stored at once, so it is not lost. A separate output shows whether a code is currently held. A read that stores nothing leaves the old content in the word but clears the held flag.

Top module: `bec_top`

## Requirements
- R1: One cycle after every cycle in which `errValid` is high, `busErrIrq` is high for exactly one cycle. This happens whether the capture is armed or locked. In all other cycles `busErrIrq` is low.
- R2: Suppose the capture is armed (`capValid` low) and `errValid` is high. In the next cycle `capWord` holds that error's fields and `capValid` is high.
- R3: While `capValid` is high and no read strobe comes, further errors leave `capWord` and `capValid` unchanged.
- R4: A `rdStrobe` cycle with no error clears `capValid` in the next cycle. `capWord` keeps its previous content.
- R5: An error in the same cycle as `rdStrobe` is stored. In the next cycle `capWord` holds it and `capValid` is high.
- R6: Word layout: bits 4:0 hold the segment code and bit 5 holds the direction (0 = transmitting, 1 = receiving). Bits 7:6 hold the kind: 00 = bit error, 01 = form error, 10 = stuff error, 11 = any other error.
- R7: Bits 31:8 of `capWord` always read zero.
- R8: While reset is asserted and right after it, `capWord` is zero and `capValid` and `busErrIrq` are low. The capture starts out armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| errValid | input | 1 | One-cycle pulse when a bus error is detected |
| errKind | input | 2 | Error kind code |
| errDir | input | 1 | 0 = transmitting, 1 = receiving |
| errSeg | input | 5 | Frame segment code of the error |
| rdStrobe | input | 1 | Software read of the capture word; re-arms the capture |
| capWord | output | 32 | Readable capture word |
| capValid | output | 1 | High while a code is held |
| busErrIrq | output | 1 | Bus error interrupt pulse |

## Verification
On every cycle the assertions check several things. An interrupt must follow each error pulse and no other cycle. A locked word and flag must not change without a read. A read without an error must clear the flag. A store must carry the previous cycle's kind, direction and segment into the right bit fields. The upper bits must stay zero. Other behaviour can only be shown by the bench's scenarios, checked against its own model. These are the full sequence through all four kind codes and both directions, the exact reset values, and long random runs that mix reads with errors. Those runs include bursts of errors while the word is locked and reads that coincide with errors.

// File: rtl/bec_pkg.sv
package bec_pkg;
  localparam int KIND_W = 2;
  localparam int SEG_W  = 5;
  localparam int CODE_W = KIND_W + 1 + SEG_W;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic              dir;
    logic [SEG_W-1:0]  seg;
  } errCode_t;

  typedef struct packed {
    logic loadCode;
    logic irqFire;
  } ctrlStrobe_t;
endpackage

// File: rtl/bec_ctrl.sv
module bec_ctrl
  import bec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        errValid,
  input  logic        rdStrobe,
  output ctrlStrobe_t strobe,
  output logic        codeValid
);
  logic armed;
  logic nextValid;

  assign armed = !codeValid || rdStrobe;

  always_comb begin
    strobe.loadCode = errValid && armed;
    strobe.irqFire  = errValid;
    if (strobe.loadCode)  nextValid = 1'b1;
    else if (rdStrobe)    nextValid = 1'b0;
    else                  nextValid = codeValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) codeValid <= 1'b0;
    else       codeValid <= nextValid;
  end

  a_r4_read_rearms: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && !errValid |=> !codeValid);

  a_r3_lock_holds_flag: assert property (@(posedge clk) disable iff (!rstN)
    codeValid && !rdStrobe |=> codeValid);
endmodule

// File: rtl/bec_datapath.sv
module bec_datapath
  import bec_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  errCode_t          errIn,
  output logic [WORD_W-1:0] capWord,
  output logic              busErrIrq
);
  localparam int PAD_W = WORD_W - CODE_W;

  errCode_t codeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeReg   <= '0;
      busErrIrq <= 1'b0;
    end else begin
      busErrIrq <= strobe.irqFire;
      if (strobe.loadCode) codeReg <= errIn;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign capWord = {{PAD_W{1'b0}}, codeReg};
    end else begin : g_nopad
      assign capWord = codeReg[WORD_W-1:0];
    end
  endgenerate

  a_r6_load_fields: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCode |=> capWord[CODE_W-1:0] == $past(errIn));

  a_r3_no_load_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadCode |=> $stable(capWord));
endmodule

// File: rtl/bec_top.sv
module bec_top
  import bec_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              errValid,
  input  logic [1:0]        errKind,
  input  logic              errDir,
  input  logic [4:0]        errSeg,
  input  logic              rdStrobe,
  output logic [WORD_W-1:0] capWord,
  output logic              capValid,
  output logic              busErrIrq
);
  ctrlStrobe_t strobe;
  errCode_t    errIn;

  assign errIn.kind = errKind;
  assign errIn.dir  = errDir;
  assign errIn.seg  = errSeg;

  bec_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .errValid (errValid),
    .rdStrobe (rdStrobe),
    .strobe   (strobe),
    .codeValid(capValid)
  );

  bec_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .errIn    (errIn),
    .capWord  (capWord),
    .busErrIrq(busErrIrq)
  );

  a_r1_irq_follows_error: assert property (@(posedge clk) disable iff (!rstN)
    errValid |=> busErrIrq);

  a_r1_irq_only_on_error: assert property (@(posedge clk) disable iff (!rstN)
    !errValid |=> !busErrIrq);

  a_r2_armed_capture: assert property (@(posedge clk) disable iff (!rstN)
    !capValid && errValid |=> capValid && capWord[7:6] == $past(errKind)
      && capWord[5] == $past(errDir) && capWord[4:0] == $past(errSeg));

  a_r5_read_and_error: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && errValid |=> capValid && capWord[4:0] == $past(errSeg));

  a_r3_locked_word: assert property (@(posedge clk) disable iff (!rstN)
    capValid && !rdStrobe |=> $stable(capWord) && capValid);

  always_comb begin
    if (rstN) a_r7_upper_zero: assert (capWord[WORD_W-1:8] == '0);
  end
endmodule

// File: tb/bec_top_bench.sv
module bec_top_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        errValid;
  logic [1:0]  errKind;
  logic        errDir;
  logic [4:0]  errSeg;
  logic        rdStrobe;
  logic [31:0] capWord;
  logic        capValid;
  logic        busErrIrq;

  int checks = 0;
  int failures = 0;
  logic [31:0] expWord;
  logic        expValid;
  logic        expIrq;
  bit          done = 0;

  always #10 clk = ~clk;

  bec_top u_bec_top (
    .clk(clk), .rstN(rstN), .errValid(errValid), .errKind(errKind),
    .errDir(errDir), .errSeg(errSeg), .rdStrobe(rdStrobe),
    .capWord(capWord), .capValid(capValid), .busErrIrq(busErrIrq)
  );

  function automatic logic [31:0] packWord(logic [1:0] k, logic d, logic [4:0] s);
    return {24'h0, k, d, s};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic ev, logic [1:0] k, logic d, logic [4:0] s, logic rd);
    string tag;
    errValid = ev; errKind = k; errDir = d; errSeg = s; rdStrobe = rd;
    if (ev && rd)             tag = "R5";
    else if (ev && !expValid) tag = "R2";
    else if (ev)              tag = "R3";
    else if (rd)              tag = "R4";
    else                      tag = "R6";
    @(posedge clk);
    expIrq = ev;
    if (ev && (!expValid || rd)) begin
      expWord = packWord(k, d, s);
      expValid = 1'b1;
    end else if (rd) begin
      expValid = 1'b0;
    end
    @(negedge clk);
    errValid = 0; rdStrobe = 0;
    chk({tag, " word"}, capWord, expWord);
    chk({tag, " valid"}, {31'h0, capValid}, {31'h0, expValid});
    chk("R1 irq", {31'h0, busErrIrq}, {31'h0, expIrq});
    chk("R7 upper", {8'h0, capWord[31:8]}, 32'h0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 0; errValid = 0; errKind = 0; errDir = 0; errSeg = 0; rdStrobe = 0;
    expWord = 0; expValid = 0; expIrq = 0;
    repeat (3) @(negedge clk);
    chk("R8 word", capWord, 32'h0);
    chk("R8 valid", {31'h0, capValid}, 32'h0);
    chk("R8 irq", {31'h0, busErrIrq}, 32'h0);
    rstN = 1;
    @(negedge clk);
    chk("R8 after release", {capWord[31:1], capValid ^ busErrIrq}, 32'h0);
    // R2 / R6: bit error, transmitting, seg 0x03
    step(1, 2'b00, 0, 5'h03, 0);
    chk("R6 layout bit", capWord, 32'h0000_0003);
    // R3: locked, stuff error ignored but irq fires
    step(1, 2'b10, 1, 5'h1F, 0);
    step(0, 0, 0, 0, 0);
    // R4: read re-arms, word kept
    step(0, 0, 0, 0, 1);
    chk("R4 word kept", capWord, 32'h0000_0003);
    // R2: form error, receiving
    step(1, 2'b01, 1, 5'h0A, 0);
    chk("R6 layout form rx", capWord, 32'h0000_006A);
    // R5: read and error in same cycle, other-kind error
    step(1, 2'b11, 0, 5'h12, 1);
    chk("R5 same-cycle", capWord, 32'h0000_00D2);
    step(0, 0, 0, 0, 1);
    step(1, 2'b10, 1, 5'h15, 0);
    chk("R6 layout stuff rx", capWord, 32'h0000_00B5);
    // back-to-back errors while locked
    for (int i = 0; i < 4; i++) step(1, 2'(i), 1'(i), 5'(i + 7), 0);
    // random mix
    for (int i = 0; i < 3000; i++)
      step(($urandom % 10) < 4, 2'($urandom), 1'($urandom), 5'($urandom),
           ($urandom % 10) < 2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule